// File: doc/BRIEF.md
# Card Controller Event Status and Interrupt Unit

This unit gathers the one-cycle event pulses from the command and data engines of a memory-card host controller. It holds each event in a sticky status bit until software drops it by writing a one to the matching bit of a separate clear register. Eleven event bits share the same bit positions across the status, clear and mask registers. The unit ANDs the held events with a software-written enable mask and ORs the result into one level-sensitive interrupt line.

The unit also samples two pins that have no clock relation to it: the card-presence pin and the write-protect pin. Each passes through a synchroniser. The synchronised levels appear live in two upper bits of the status word. Every toggle of the synchronised card-presence level, in either direction, sets a card-change event that is held and masked like any other event. Software reaches the unit through a small register port with one write strobe and one read strobe. Read data is registered.

Top module: `sia_status_unit`

## Requirements
- R1: A high on `evt_pulse[i]` (i = 0..9) in a clock cycle sets status bit i. The bit stays set until it is cleared. Bit meanings: 0 response CRC error, 1 data CRC error, 2 response timeout, 3 data timeout, 4 response CRC good, 5 data CRC good, 6 command issued, 7 data finished, 8 FIFO underrun, 9 FIFO overrun.
- R2: A write to address 1 (clear register) clears each status bit 0..10 whose write-data bit is 1. A write-data bit of 0 leaves the matching status bit unchanged.
- R3: When an event sets a bit in the same cycle that a clear write targets it, the bit stays set. Other bits named in that clear are still cleared.
- R4: Every change of the synchronised card-presence level, rising or falling, sets status bit 10 (card change). The bit becomes visible no later than three clock edges after the pin changes.
- R5: Status bit 11 reads the synchronised card-presence pin, where 1 means no card. Status bit 12 reads the synchronised write-protect pin. Bits 31..13 always read 0.
- R6: Address 2 is the mask register. A write stores bits 10..0 of the write data. A read returns the stored value with bits 31..11 as 0.
- R7: `irq` is high exactly when some bit 0..10 is set in both status and mask. `irq` is a level and stays low whenever the mask is all zero.
- R8: After reset the event bits are 0, the mask is 0 and `irq` is low. The synchronisers reset to "no card" and "not protected".
- R9: A write to address 0 (status) has no effect on the status word.
- R10: A read strobe returns its data on `reg_rdata` after the next clock edge. Address 0 returns status, address 2 returns the mask, and addresses 1 and 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address: 0 status, 1 clear, 2 mask, 3 reserved |
| reg_wdata | input | 11 | Write data, one bit per event position |
| reg_rdata | output | 32 | Registered read data |
| evt_pulse | input | 10 | Event pulses from the command and data engines (bits 0..9) |
| card_absent | input | 1 | Asynchronous card-presence pin, 1 = no card |
| wr_protect | input | 1 | Asynchronous write-protect pin |
| irq | output | 1 | Level interrupt request |

## Verification
The bench drives an event and a clear onto the same bit in the same cycle. A design that gives priority to the clear would lose that event and read the bit back as 0. A write to the status address is followed by a read-back. A design that decodes the status address as writable would clear or set bits there. The card-presence pin is toggled both ways, and bit 10 is expected to set each time. An edge detector that saw only one direction, or that compared against the unsynchronised pin, would miss a toggle or report a stale level in bit 11. The mask is switched between a bit that is pending and one that is not. A wrong AND/OR reduction, or a latched interrupt, would then show the wrong level on `irq`.

// File: rtl/sia_pkg.sv
package sia_pkg;

    localparam int WORD_W      = 32;
    localparam int ADDR_W      = 2;
    localparam int EVT_W       = 11;
    localparam int EXT_EVT_W   = EVT_W - 1;
    localparam int CHG_BIT     = EVT_W - 1;
    localparam int CD_BIT      = EVT_W;
    localparam int WP_BIT      = EVT_W + 1;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADR_STATUS = 2'd0,
        ADR_CLEAR  = 2'd1,
        ADR_MASK   = 2'd2,
        ADR_RSVD   = 2'd3
    } sia_addr_e;

    typedef struct packed {
        logic             wr;
        logic             rd;
        sia_addr_e        addr;
        logic [EVT_W-1:0] wdata;
    } sia_req_t;

    typedef struct packed {
        logic card_absent;
        logic wr_protect;
    } sia_pins_t;

    function automatic logic [WORD_W-1:0] pack_status(
        input logic [EVT_W-1:0] evts,
        input sia_pins_t        pins
    );
        logic [WORD_W-1:0] w;
        w          = '0;
        w[EVT_W-1:0] = evts;
        w[CD_BIT]  = pins.card_absent;
        w[WP_BIT]  = pins.wr_protect;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] widen(input logic [EVT_W-1:0] v);
        return {{(WORD_W-EVT_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/sia_sync.sv
module sia_sync #(
    parameter int   W       = 2,
    parameter int   STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= RST_VAL;
                    else     stage_q[s] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= RST_VAL;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/sia_toggle_det.sv
module sia_toggle_det #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic toggled
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= RST_VAL;
        else     prev_q <= level;
    end

    assign toggled = level ^ prev_q;
endmodule

// File: rtl/sia_evt_reg.sv
module sia_evt_reg #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] held
);
    generate
        for (genvar b = 0; b < W; b++) begin : g_bit
            logic bit_q;
            always_ff @(posedge clk) begin
                if (rst)             bit_q <= 1'b0;
                else if (set_vec[b]) bit_q <= 1'b1;
                else if (clr_vec[b]) bit_q <= 1'b0;
            end
            assign held[b] = bit_q;
        end
    endgenerate
endmodule

// File: rtl/sia_irq_gen.sv
module sia_irq_gen #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         mask_we,
    input  logic [W-1:0] mask_wdata,
    input  logic [W-1:0] events,
    output logic [W-1:0] mask,
    output logic         irq
);
    logic [W-1:0] mask_q;
    logic [W-1:0] hit;

    always_ff @(posedge clk) begin
        if (rst)          mask_q <= '0;
        else if (mask_we) mask_q <= mask_wdata;
    end

    always_comb begin
        hit = events & mask_q;
    end

    assign mask = mask_q;
    assign irq  = |hit;
endmodule

// File: rtl/sia_status_unit.sv
module sia_status_unit
    import sia_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    reg_wr,
    input  logic                    reg_rd,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [EVT_W-1:0]        reg_wdata,
    output logic [WORD_W-1:0]       reg_rdata,
    input  logic [EXT_EVT_W-1:0]    evt_pulse,
    input  logic                    card_absent,
    input  logic                    wr_protect,
    output logic                    irq
);
    sia_req_t          req;
    sia_pins_t         pins_raw;
    sia_pins_t         pins_s;
    logic [1:0]        pins_s_vec;
    logic              chg_evt;
    logic [EVT_W-1:0]  set_vec;
    logic [EVT_W-1:0]  clr_vec;
    logic [EVT_W-1:0]  status_q;
    logic [EVT_W-1:0]  mask_q;
    logic              mask_we;
    logic [WORD_W-1:0] rd_mux;
    logic [WORD_W-1:0] rdata_q;

    always_comb begin
        req.wr    = reg_wr;
        req.rd    = reg_rd;
        req.addr  = sia_addr_e'(reg_addr);
        req.wdata = reg_wdata;
    end

    assign pins_raw.card_absent = card_absent;
    assign pins_raw.wr_protect  = wr_protect;

    // Pin synchronisers: reset to "no card, not protected"
    sia_sync #(
        .W       (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (2'b10)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (pins_raw),
        .q_sync  (pins_s_vec)
    );
    assign pins_s = sia_pins_t'(pins_s_vec);

    sia_toggle_det #(
        .RST_VAL (1'b1)
    ) u_cd_edge (
        .clk     (clk),
        .rst     (rst),
        .level   (pins_s.card_absent),
        .toggled (chg_evt)
    );

    assign set_vec = {chg_evt, evt_pulse};
    assign clr_vec = (req.wr && req.addr == ADR_CLEAR) ? req.wdata : '0;
    assign mask_we = req.wr && req.addr == ADR_MASK;

    sia_evt_reg #(
        .W (EVT_W)
    ) u_evts (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .held    (status_q)
    );

    sia_irq_gen #(
        .W (EVT_W)
    ) u_irq (
        .clk        (clk),
        .rst        (rst),
        .mask_we    (mask_we),
        .mask_wdata (req.wdata),
        .events     (status_q),
        .mask       (mask_q),
        .irq        (irq)
    );

    always_comb begin
        unique case (req.addr)
            ADR_STATUS: rd_mux = pack_status(status_q, pins_s);
            ADR_MASK:   rd_mux = widen(mask_q);
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (req.rd) rdata_q <= rd_mux;
    end

    assign reg_rdata = rdata_q;
endmodule

// File: rtl/sia_checker.sv
module sia_checker
    import sia_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic [EVT_W-1:0]     set_vec,
    input logic [EVT_W-1:0]     clr_vec,
    input logic [EVT_W-1:0]     status,
    input logic [EVT_W-1:0]     mask,
    input logic                 mask_we,
    input logic                 cd_level,
    input logic [WORD_W-1:0]    reg_rdata,
    input logic                 irq
);
    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (rst)
        (|set_vec) |=> ((status & $past(set_vec)) == $past(set_vec))); // R1

    AST_HELD_WITHOUT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clr_vec == '0) |=> ((status & $past(status)) == $past(status))); // R1

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
        (|clr_vec) |=> ((status & $past(clr_vec) & ~$past(set_vec)) == '0)); // R2

    AST_CHANGE_ON_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (cd_level != $past(cd_level)) |=> status[CHG_BIT]); // R4

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[WORD_W-1:WP_BIT+1] == '0); // R5

    AST_MASK_STABLE: assert property (@(posedge clk) disable iff (rst)
        !mask_we |=> $stable(mask)); // R6

    AST_NO_MASK_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |-> !irq); // R7

    AST_IRQ_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst)
        irq |-> (status != '0)); // R7
endmodule

bind sia_status_unit sia_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .set_vec   (set_vec),
    .clr_vec   (clr_vec),
    .status    (status_q),
    .mask      (mask_q),
    .mask_we   (mask_we),
    .cd_level  (pins_s.card_absent),
    .reg_rdata (reg_rdata),
    .irq       (irq)
);

// File: tb/tb_sia_status_unit.sv
`timescale 1ns/1ps
module tb_sia_status_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [10:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [9:0]  evt_pulse = '0;
    logic        card_absent = 1'b1;
    logic        wr_protect = 1'b0;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        rd_d = 1'b0;

    always #2 clk = ~clk;

    sia_status_unit dut (
        .clk         (clk),
        .rst         (rst),
        .reg_wr      (reg_wr),
        .reg_rd      (reg_rd),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .evt_pulse   (evt_pulse),
        .card_absent (card_absent),
        .wr_protect  (wr_protect),
        .irq         (irq)
    );

    always @(posedge clk) rd_d <= reg_rd;

    // Monitor: pops expected read data one cycle after each read strobe
    always @(negedge clk) begin
        if (rd_d && !rst) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL unexpected read: actual %h expected none", reg_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (reg_rdata !== e) begin
                    fails++;
                    $display("FAIL %s: actual %h expected %h", t, reg_rdata, e);
                end
            end
        end
    end

    task automatic drive(input logic wr, input logic [1:0] a,
                         input logic [10:0] d, input logic [9:0] ev);
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = d; evt_pulse = ev;
        @(negedge clk);
        reg_wr = 1'b0; evt_pulse = '0;
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [10:0] d);
        drive(1'b1, a, d, '0);
    endtask

    task automatic read_expect(input logic [1:0] a, input logic [31:0] e,
                               input string t);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic irq_expect(input logic e, input string t);
        @(negedge clk);
        checks++;
        if (irq !== e) begin
            fails++;
            $display("FAIL %s: actual irq %b expected %b", t, irq, e);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        irq_expect(1'b0, "R8 irq after reset");
        read_expect(2'd0, 32'h800, "R8 R5 status after reset");
        read_expect(2'd2, 32'h0,   "R8 mask after reset");

        drive(1'b0, 2'd0, '0, 10'h081);
        read_expect(2'd0, 32'h881, "R1 events held");
        irq_expect(1'b0, "R7 masked off");

        wr_reg(2'd2, 11'h7FF);
        read_expect(2'd2, 32'h7FF, "R6 mask readback");
        irq_expect(1'b1, "R7 irq with mask");

        wr_reg(2'd1, 11'h001);
        read_expect(2'd0, 32'h880, "R2 clear one bit");
        wr_reg(2'd1, 11'h000);
        read_expect(2'd0, 32'h880, "R2 zero clear no effect");

        wr_reg(2'd0, 11'h7FF);
        read_expect(2'd0, 32'h880, "R9 status write ignored");

        drive(1'b1, 2'd1, 11'h088, 10'h008);
        read_expect(2'd0, 32'h808, "R3 event beats clear");

        wr_reg(2'd1, 11'h7FF);
        read_expect(2'd0, 32'h800, "R2 clear all");
        irq_expect(1'b0, "R7 nothing pending");

        wr_reg(2'd2, 11'h000);
        drive(1'b0, 2'd0, '0, 10'h200);
        irq_expect(1'b0, "R7 zero mask");
        wr_reg(2'd2, 11'h200);
        irq_expect(1'b1, "R7 pending bit enabled");
        wr_reg(2'd2, 11'h100);
        irq_expect(1'b0, "R7 other bit enabled");

        @(negedge clk); card_absent = 1'b0;
        repeat (4) @(negedge clk);
        read_expect(2'd0, 32'h600, "R4 R5 card inserted");
        wr_reg(2'd1, 11'h400);
        read_expect(2'd0, 32'h200, "R2 clear card change");
        @(negedge clk); card_absent = 1'b1;
        repeat (4) @(negedge clk);
        read_expect(2'd0, 32'hE00, "R4 card removed");

        @(negedge clk); wr_protect = 1'b1;
        repeat (4) @(negedge clk);
        read_expect(2'd0, 32'h1E00, "R5 write protect level");

        read_expect(2'd1, 32'h0, "R10 clear address reads zero");
        read_expect(2'd3, 32'h0, "R10 reserved address reads zero");

        wr_reg(2'd1, 11'h7FF);
        drive(1'b0, 2'd0, '0, 10'h3FF);
        read_expect(2'd0, 32'h1BFF, "R1 all engine events");
        wr_reg(2'd2, 11'h7FF);
        irq_expect(1'b1, "R7 all enabled");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; fails++;
            $display("FAIL R10 reads outstanding: actual %0d expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule